// File: doc/BRIEF.md
# State-of-Charge LED Bar Display

This block turns a relative state-of-charge percentage into a five-segment bar on active-low LED outputs. Segments light as a cumulative bar, starting at the lowest LED and working upward. The thresholds are not evenly spaced. When the charge is at or below the lowest threshold, the bottom LED blinks instead. A one-second tick from elsewhere in the chip paces both the blink and every timeout.

While the pack is charging or discharging, the bar stays on. When the pack is idle, the bar stays lit for a five-tick hold window and then goes dark. A falling edge on a display-request button opens a new window, but only when the pack is idle. The button is first resynchronised through two flops. A change in the number of lit segments during a window restarts the hold, and so does another button press.

The controller has three states:
- `ST_DARK`: all LEDs are off.
- `ST_ACTIVE`: the pack is charging or discharging.
- `ST_WINDOW`: the timed idle display.

It has these named transitions:
- `ST_DARK`→`ST_ACTIVE` on busy.
- `ST_DARK`→`ST_WINDOW` on a button fall.
- `ST_ACTIVE`→`ST_WINDOW` when busy drops.
- `ST_WINDOW`→`ST_ACTIVE` on busy.
- `ST_WINDOW`→`ST_WINDOW` (reload) on a level change or a button fall.
- `ST_WINDOW`→`ST_DARK` when the hold count runs out.

Top module: `soc_bar_display`

## Requirements
- R1: Outputs are active low. `led_n[0]` is the lowest segment and `led_n[4]` the highest. Lit segments always form a contiguous run starting at `led_n[0]`, and in `ST_DARK` all five outputs are high.
- R2: A percentage strictly greater than 10, 25, 50, 75 or 90 lights one, two, three, four or five segments respectively. For example, 25 lights one segment and 26 lights two.
- R3: At 10 percent or below, only `led_n[0]` may be low. A blink phase, which is lit after reset, toggles on every `sec_tick`, and `led_n[0]` follows it.
- R4: While `chg` or `dis` is high, the bar is shown continuously, no matter how many ticks arrive.
- R5: When both `chg` and `dis` fall low, the bar stays on through four further ticks and goes dark on the fifth.
- R6: From dark with the pack idle, a falling edge on `disp_btn` (high then low) lights the bar for a five-tick window.
- R7: Rising edges and steady levels on `disp_btn` never light the bar. A falling edge that occurs while the pack is busy does not lengthen the idle hold that follows.
- R8: During an idle window, a change in the lit-segment count or a new falling edge on `disp_btn` restarts the full five-tick hold.
- R9: While `rst_n` is low and after its release, the block is dark with all outputs high.
- R10: Percentages above 100, up to the maximum of the input width, light all five segments.
- R11: The outputs reflect a new input within six clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soc_pct | input | 7 | Relative state of charge, in percent |
| chg | input | 1 | Pack is charging |
| dis | input | 1 | Pack is discharging |
| disp_btn | input | 1 | Display request, idle high, asynchronous |
| sec_tick | input | 1 | One-cycle pulse once per second |
| led_n | output | 5 | Bar segments, active low, bit 0 is the lowest |

## Verification
A wrong state or hold count shows up at the ports as a bar that goes dark one tick early, lingers one tick late, or never lights at all. Each of these is visible within one tick of the expected expiry. A stale level-change register shows up as a window that fails to restart after a threshold crossing. A blink phase that is off by one shows up as the lowest segment inverted on the first tick after reset. A fault in the threshold map shows up within two cycles of a percentage change, while the pack is busy.

// File: rtl/soc_bar_pkg.sv
package soc_bar_pkg;

    typedef enum logic [1:0] {
        ST_DARK   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_WINDOW = 2'd2
    } disp_st_e;

endpackage

// File: rtl/soc_bar_sync.sv
module soc_bar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_async,
    output logic btn_fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], btn_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign btn_fall = prev_q & ~sync_q[STAGES-1];

    // R6: an edge pulse lasts exactly one cycle
    a_r6_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        btn_fall |=> !btn_fall);

endmodule

// File: rtl/soc_bar_level.sv
module soc_bar_level #(
    parameter int                   PCT_W = 7,
    parameter int                   SEGS  = 5,
    parameter logic [SEGS*PCT_W-1:0] THR  = {7'd90, 7'd75, 7'd50, 7'd25, 7'd10}
) (
    input  logic [PCT_W-1:0] pct,
    output logic [SEGS-1:0]  mask
);
    for (genvar i = 0; i < SEGS; i++) begin : g_cmp
        localparam logic [PCT_W-1:0] LIMIT = THR[i*PCT_W +: PCT_W];
        assign mask[i] = (pct > LIMIT);
    end

endmodule

// File: rtl/soc_bar_ctrl.sv
module soc_bar_ctrl
    import soc_bar_pkg::*;
#(
    parameter int SEGS     = 5,
    parameter int HOLD_SEC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic            btn_fall,
    input  logic            sec_tick,
    input  logic [SEGS-1:0] mask,
    output logic [SEGS-1:0] led_n
);
    localparam int TW = $clog2(HOLD_SEC + 1);
    localparam logic [TW-1:0] HOLD_LD = TW'(HOLD_SEC);

    disp_st_e        state_q, state_d;
    logic [TW-1:0]   timer_q, timer_d;
    logic [SEGS-1:0] mask_q;
    logic            phase_q;
    logic            lvl_chg;

    assign lvl_chg = (mask != mask_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        unique case (state_q)
            ST_DARK: begin
                if (busy) begin
                    state_d = ST_ACTIVE;
                end else if (btn_fall) begin
                    state_d = ST_WINDOW;
                    timer_d = HOLD_LD;
                end
            end
            ST_ACTIVE: begin
                if (!busy) begin
                    state_d = ST_WINDOW;
                    timer_d = HOLD_LD;
                end
            end
            ST_WINDOW: begin
                if (busy) begin
                    state_d = ST_ACTIVE;
                end else if (btn_fall || lvl_chg) begin
                    timer_d = HOLD_LD;
                end else if (sec_tick) begin
                    if (timer_q <= TW'(1)) begin
                        state_d = ST_DARK;
                        timer_d = '0;
                    end else begin
                        timer_d = timer_q - TW'(1);
                    end
                end
            end
            default: begin
                state_d = ST_DARK;
                timer_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DARK;
            timer_q <= '0;
            mask_q  <= '0;
            phase_q <= 1'b1;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
            mask_q  <= mask;
            if (sec_tick) phase_q <= ~phase_q;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_n <= '1;
        end else if (state_q == ST_DARK) begin
            led_n <= '1;
        end else if (mask == '0) begin
            led_n <= ~{{(SEGS-1){1'b0}}, phase_q};
        end else begin
            led_n <= ~mask;
        end
    end

    // R1: dark state drives every segment off on the next cycle
    a_r1_dark_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DARK) |=> (led_n == '1));

    // R2: comparator outputs form a thermometer code
    a_r2_thermo: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & (mask + SEGS'(1))) == '0));

    // R3: blink phase flips on every tick
    a_r3_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (phase_q != $past(phase_q)));

    // R4: busy always leads to the continuous state
    a_r4_busy_active: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state_q == ST_ACTIVE));

    // R5: hold counter never exceeds its load value
    a_r5_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        timer_q <= HOLD_LD);

    // R8: a restart cause inside a window reloads the full hold
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WINDOW && !busy && (btn_fall || lvl_chg))
            |=> (state_q == ST_WINDOW && timer_q == HOLD_LD));

    // R5: last tick of a window ends it
    a_r5_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WINDOW && !busy && !btn_fall && !lvl_chg
            && sec_tick && timer_q == TW'(1)) |=> (state_q == ST_DARK));

endmodule

// File: rtl/soc_bar_display.sv
module soc_bar_display #(
    parameter int PCT_W    = 7,
    parameter int HOLD_SEC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PCT_W-1:0] soc_pct,
    input  logic             chg,
    input  logic             dis,
    input  logic             disp_btn,
    input  logic             sec_tick,
    output logic [4:0]       led_n
);
    localparam int SEGS = 5;

    logic            btn_fall;
    logic [SEGS-1:0] mask;

    soc_bar_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn_async (disp_btn),
        .btn_fall  (btn_fall)
    );

    soc_bar_level #(
        .PCT_W (PCT_W),
        .SEGS  (SEGS),
        .THR   ({PCT_W'(90), PCT_W'(75), PCT_W'(50), PCT_W'(25), PCT_W'(10)})
    ) u_level (
        .pct  (soc_pct),
        .mask (mask)
    );

    soc_bar_ctrl #(
        .SEGS     (SEGS),
        .HOLD_SEC (HOLD_SEC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (chg | dis),
        .btn_fall (btn_fall),
        .sec_tick (sec_tick),
        .mask     (mask),
        .led_n    (led_n)
    );

endmodule

// File: tb/soc_bar_display_tb.sv
module soc_bar_display_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] soc_pct = 7'd60;
    logic       chg = 1'b0;
    logic       dis = 1'b0;
    logic       disp_btn = 1'b1;
    logic       sec_tick = 1'b0;
    logic [4:0] led_n;

    int checks = 0;
    int errors = 0;
    int ticks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    soc_bar_display u_dut (
        .clk(clk), .rst_n(rst_n), .soc_pct(soc_pct), .chg(chg), .dis(dis),
        .disp_btn(disp_btn), .sec_tick(sec_tick), .led_n(led_n)
    );

    // {pct, expected led_n}, pack busy, no blinking
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        {7'd11,  5'b11110}, {7'd25,  5'b11110}, {7'd26,  5'b11100},
        {7'd50,  5'b11100}, {7'd51,  5'b11000}, {7'd75,  5'b11000},
        {7'd76,  5'b10000}, {7'd90,  5'b10000}, {7'd91,  5'b00000},
        {7'd100, 5'b00000}, {7'd127, 5'b00000}, {7'd30,  5'b11100},
        {7'd60,  5'b11000}
    };

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [4:0] exp);
        checks++;
        if (led_n !== exp) begin
            errors++;
            $display("FAIL %s led_n=%b expected=%b", req, led_n, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        ticks++;
        wait_cyc(3);
    endtask

    task automatic press();
        disp_btn = 1'b0;
        wait_cyc(6);
        disp_btn = 1'b1;
        wait_cyc(6);
    endtask

    initial begin
        wait_cyc(3);
        check("R9 in reset", 5'b11111);
        rst_n = 1'b1;
        wait_cyc(6);
        check("R9 after reset", 5'b11111);

        // R7: rising edge and steady level do not light
        disp_btn = 1'b0;
        chg = 1'b1;
        wait_cyc(6);
        chg = 1'b0;
        wait_cyc(6);
        for (int t = 0; t < 5; t++) tick();
        check("R7 fall while busy did not extend hold", 5'b11111);
        disp_btn = 1'b1;
        wait_cyc(8);
        check("R7 rising edge ignored", 5'b11111);

        // R2/R10/R11: threshold table while charging
        chg = 1'b1;
        for (int v = 0; v < NV; v++) begin
            soc_pct = VEC[v][11:5];
            wait_cyc(6);
            check("R2 R10 R11 threshold map", VEC[v][4:0]);
        end

        // R4: discharging, many ticks, stays on
        chg = 1'b0;
        dis = 1'b1;
        soc_pct = 7'd60;
        for (int t = 0; t < 8; t++) tick();
        check("R4 busy no timeout", 5'b11000);

        // R3: blink at 10 percent and below
        soc_pct = 7'd10;
        wait_cyc(6);
        check("R3 blink phase", (ticks % 2 == 0) ? 5'b11110 : 5'b11111);
        tick();
        check("R3 blink toggles", (ticks % 2 == 0) ? 5'b11110 : 5'b11111);
        soc_pct = 7'd0;
        tick();
        check("R3 blink at zero", (ticks % 2 == 0) ? 5'b11110 : 5'b11111);

        // R5: leaving busy, hold 5 ticks
        soc_pct = 7'd40;
        wait_cyc(4);
        dis = 1'b0;
        wait_cyc(6);
        for (int t = 0; t < 4; t++) tick();
        check("R5 still on after four ticks", 5'b11100);
        tick();
        check("R5 dark after fifth tick", 5'b11111);

        // R6: button fall from dark
        press();
        check("R6 button lights bar", 5'b11100);
        for (int t = 0; t < 3; t++) tick();
        // R8: level change restarts
        soc_pct = 7'd80;
        wait_cyc(6);
        check("R8 new level shown", 5'b10000);
        for (int t = 0; t < 4; t++) tick();
        check("R8 restart by level change", 5'b10000);
        // R8: button fall restarts
        press();
        for (int t = 0; t < 4; t++) tick();
        check("R8 restart by button", 5'b10000);
        tick();
        check("R8 window ends", 5'b11111);

        // R1: contiguous bar and all-off when dark
        chg = 1'b1;
        soc_pct = 7'd55;
        wait_cyc(6);
        check("R1 contiguous from bottom", 5'b11000);

        // R9: reset mid-display
        rst_n = 1'b0;
        wait_cyc(2);
        check("R9 reset clears display", 5'b11111);
        chg = 1'b0;
        rst_n = 1'b1;
        wait_cyc(6);
        check("R9 dark after second reset", 5'b11111);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule